// File: doc/BRIEF.md
# Multi-Bridge Configuration Claim Logic

This block is the configuration-access decision logic of one host bridge that may share a host bus with a second bridge. Both bridges keep a copy of a shared configuration address register, which selects bus, device, function and dword. When the host then accesses the configuration data port, each bridge takes one of three actions. It can answer from its own small internal register file, forward the access as a downstream configuration request, or stay silent.

A strap input chooses the bridge's role, either compatibility or auxiliary. The role sets its internal device number and how it behaves before firmware has assigned bus numbers. After reset the two bridges never claim the same access. The compatibility bridge takes the downstream devices on bus 0. The auxiliary bridge answers only for its own pseudo-device until software gives it a non-zero secondary bus. The host port is a single-cycle request with a registered response one cycle later. A forwarded access leaves the block as a one-cycle request that carries the decoded fields.

Top module: `cfg_claim`

## Requirements
- R1: After reset no response or forward request is active, and the secondary and subordinate bus numbers read back as zero.
- R2: A write to the address port (`hsel_data`=0) stores bit 31 and bits 23:2; bits 30:24 and 1:0 are stored as zero. Both roles capture the write. Only the compatibility role acknowledges address-port accesses and returns the stored value on a read. The auxiliary role does not acknowledge them and returns all-ones.
- R3: A data access while stored bit 31 (enable) is clear is never acknowledged or forwarded.
- R4: With bus (bits 23:16) = 0 and device (bits 15:11) >= 16, the bridge claims the access internally only when the device equals its own number (default 25 compatibility, 26 auxiliary). Other devices of 16 or above are ignored.
- R5: Internal dword 0 reads as the parameter `ID_WORD` (default 32'h51C0_7A3D). Internal dwords other than 0 and the bus-number dword read as zero.
- R6: Internal dword 6 (dword field bits 7:2) holds the secondary bus number in bits 7:0 and the subordinate bus number in bits 15:8, with the other bits zero. An internal write to it updates both fields.
- R7: An access whose bus equals the secondary bus is forwarded as type 0 (`fwd_type1`=0) when the bus is non-zero or the device is below 16. The auxiliary role forwards nothing while its secondary bus is zero.
- R8: An access with secondary < bus <= subordinate is forwarded as type 1.
- R9: A forward request carries bus, device, function and dword from the address register, plus the direction and the write data (zero on reads).
- R10: An access that no rule claims gets no acknowledge. A read returns all-ones and a write produces no forward request.
- R11: Every request gets exactly one response, registered one cycle after the request.
- R12: A bus-number write governs the decode of the request that immediately follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_aux | input | 1 | Role strap: 0 compatibility, 1 auxiliary |
| hreq | input | 1 | Host request, one cycle per access |
| hwr | input | 1 | 1 write, 0 read |
| hsel_data | input | 1 | 0 address port, 1 data port |
| hwdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Response strobe, one cycle after hreq |
| rsp_ack | output | 1 | This bridge claims the access |
| rsp_rdata | output | 32 | Read data (zero for writes and forwarded reads) |
| fwd_req | output | 1 | Downstream configuration request |
| fwd_type1 | output | 1 | 1 type-1 cycle, 0 type-0 cycle |
| fwd_wr | output | 1 | Forwarded direction |
| fwd_bus | output | 8 | Forwarded bus |
| fwd_dev | output | 5 | Forwarded device |
| fwd_func | output | 3 | Forwarded function |
| fwd_dword | output | 6 | Forwarded dword |
| fwd_wdata | output | 32 | Forwarded write data |

## Verification
A bus-number update and the decode of the next access meet in one clock cycle. The response that commits the new secondary and subordinate values is registered on the same edge that accepts the following request. The bench provokes this by issuing the bus-number write and the next access back to back, with no idle cycle between them. It judges the result with a two-bridge scoreboard that predicts the new range, which is one compatibility and one auxiliary instance on a shared bus. A second overlap is ownership: every access is sent to both bridges at once, and the bench checks that at most one of them acknowledges or forwards it.

// File: rtl/cfg_claim.sv
module cfg_claim #(
  parameter logic [4:0]  COMPAT_DEV = 5'd25,
  parameter logic [4:0]  AUX_DEV    = 5'd26,
  parameter logic [5:0]  BUSREG_DW  = 6'd6,
  parameter logic [31:0] ID_WORD    = 32'h51C0_7A3D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_aux,
  input  logic        hreq,
  input  logic        hwr,
  input  logic        hsel_data,
  input  logic [31:0] hwdata,
  output logic        rsp_valid,
  output logic        rsp_ack,
  output logic [31:0] rsp_rdata,
  output logic        fwd_req,
  output logic        fwd_type1,
  output logic        fwd_wr,
  output logic [7:0]  fwd_bus,
  output logic [4:0]  fwd_dev,
  output logic [2:0]  fwd_func,
  output logic [5:0]  fwd_dword,
  output logic [31:0] fwd_wdata
);
  localparam logic [31:0] ADDR_MASK = 32'h80FF_FFFC;
  localparam logic [31:0] ONES      = '1;

  logic [31:0] cfg_addr;
  logic [7:0]  sec_bus, sub_bus;

  wire        a_en   = cfg_addr[31];
  wire [7:0]  a_bus  = cfg_addr[23:16];
  wire [4:0]  a_dev  = cfg_addr[15:11];
  wire [2:0]  a_fn   = cfg_addr[10:8];
  wire [5:0]  a_dw   = cfg_addr[7:2];
  wire [4:0]  own_dev = strap_aux ? AUX_DEV : COMPAT_DEV;
  wire        armed  = !strap_aux || (sec_bus != 8'd0);

  wire hit_int = a_en && (a_bus == 8'd0) && (a_dev >= 5'd16) && (a_dev == own_dev);
  wire hit_t0  = a_en && armed && (a_bus == sec_bus) && ((a_bus != 8'd0) || (a_dev < 5'd16));
  wire hit_t1  = a_en && armed && (a_bus > sec_bus) && (a_bus <= sub_bus);
  wire hit_fwd = hit_t0 || hit_t1;

  wire addr_acc = hreq && !hsel_data;
  wire data_acc = hreq && hsel_data;
  wire busreg_wr = data_acc && hwr && hit_int && (a_dw == BUSREG_DW);

  logic [31:0] int_rdata;
  always_comb begin
    if (a_dw == 6'd0)           int_rdata = ID_WORD;
    else if (a_dw == BUSREG_DW) int_rdata = {16'h0, sub_bus, sec_bus};
    else                        int_rdata = '0;
  end

  logic [31:0] rd_next;
  always_comb begin
    if (hwr)            rd_next = '0;
    else if (!hsel_data) rd_next = strap_aux ? ONES : cfg_addr;
    else if (hit_int)   rd_next = int_rdata;
    else if (hit_fwd)   rd_next = '0;
    else                rd_next = ONES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_addr <= '0;
      sec_bus  <= '0;
      sub_bus  <= '0;
    end else begin
      if (addr_acc && hwr) cfg_addr <= hwdata & ADDR_MASK;
      if (busreg_wr) begin
        sec_bus <= hwdata[7:0];
        sub_bus <= hwdata[15:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_rdata <= '0;
      fwd_req   <= 1'b0;
      fwd_type1 <= 1'b0;
      fwd_wr    <= 1'b0;
      fwd_bus   <= '0;
      fwd_dev   <= '0;
      fwd_func  <= '0;
      fwd_dword <= '0;
      fwd_wdata <= '0;
    end else begin
      rsp_valid <= hreq;
      rsp_ack   <= hreq && (hsel_data ? (hit_int || hit_fwd) : !strap_aux);
      rsp_rdata <= hreq ? rd_next : '0;
      fwd_req   <= data_acc && hit_fwd;
      if (data_acc && hit_fwd) begin
        fwd_type1 <= !hit_t0;
        fwd_wr    <= hwr;
        fwd_bus   <= a_bus;
        fwd_dev   <= a_dev;
        fwd_func  <= a_fn;
        fwd_dword <= a_dw;
        fwd_wdata <= hwr ? hwdata : '0;
      end else begin
        fwd_type1 <= 1'b0;
        fwd_wr    <= 1'b0;
        fwd_bus   <= '0;
        fwd_dev   <= '0;
        fwd_func  <= '0;
        fwd_dword <= '0;
        fwd_wdata <= '0;
      end
    end
  end

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq |=> rsp_valid);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hreq |=> !rsp_valid && !fwd_req);
  // R3
  disabled_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !cfg_addr[31] |=> !rsp_ack && !fwd_req);
  // R2
  aux_addr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_acc && strap_aux |=> !rsp_ack);
  // R7
  aux_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_aux && (sec_bus == 8'd0) |=> !fwd_req);
  // R7
  bus0_type0_low_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req && !fwd_type1 && (fwd_bus == 8'd0) |-> fwd_dev < 5'd16);
  // R9
  fwd_implies_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req |-> rsp_valid && rsp_ack);
endmodule

// File: tb/cfg_claim_bench.sv
`timescale 1ns/1ps
module cfg_claim_bench;
  typedef struct packed {
    logic        ack;
    logic [31:0] rdata;
    logic        fwd;
    logic        t1;
    logic        wr;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [5:0]  dw;
    logic [31:0] wdata;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic hreq = 0, hwr = 0, hsel_data = 0;
  logic [31:0] hwdata = '0;
  always #5 clk = ~clk;

  logic        v0, a0, f0, t0, w0, v1, a1, f1, t1, w1;
  logic [31:0] r0, r1, wd0, wd1;
  logic [7:0]  b0, b1;
  logic [4:0]  d0, d1;
  logic [2:0]  fn0, fn1;
  logic [5:0]  dw0, dw1;

  cfg_claim u_cfg_claim (.clk, .rst_n, .strap_aux(1'b0), .hreq, .hwr, .hsel_data, .hwdata,
    .rsp_valid(v0), .rsp_ack(a0), .rsp_rdata(r0), .fwd_req(f0), .fwd_type1(t0), .fwd_wr(w0),
    .fwd_bus(b0), .fwd_dev(d0), .fwd_func(fn0), .fwd_dword(dw0), .fwd_wdata(wd0));
  cfg_claim u_cfg_claim_aux (.clk, .rst_n, .strap_aux(1'b1), .hreq, .hwr, .hsel_data, .hwdata,
    .rsp_valid(v1), .rsp_ack(a1), .rsp_rdata(r1), .fwd_req(f1), .fwd_type1(t1), .fwd_wr(w1),
    .fwd_bus(b1), .fwd_dev(d1), .fwd_func(fn1), .fwd_dword(dw1), .fwd_wdata(wd1));

  int checks = 0, fails = 0;
  item_t q0[$], q1[$];
  string g0[$], g1[$];
  logic [31:0] m_addr = '0;
  logic [7:0]  m_sec[2] = '{8'd0, 8'd0};
  logic [7:0]  m_sub[2] = '{8'd0, 8'd0};

  function automatic item_t predict(int b, bit sel, bit wr, logic [31:0] d);
    item_t e = '0;
    logic en = m_addr[31];
    logic [7:0] bus = m_addr[23:16];
    logic [4:0] dev = m_addr[15:11];
    logic [5:0] dw = m_addr[7:2];
    logic [4:0] own = (b == 1) ? 5'd26 : 5'd25;
    logic armed = (b == 0) || (m_sec[b] != 0);
    logic in_int, ty0, ty1;
    if (!sel) begin
      e.ack = (b == 0);
      e.rdata = wr ? 32'h0 : ((b == 1) ? 32'hFFFF_FFFF : m_addr);
      return e;
    end
    in_int = en && bus == 0 && dev == own;
    ty0 = en && armed && bus == m_sec[b] && (bus != 0 || dev < 16);
    ty1 = en && armed && bus > m_sec[b] && bus <= m_sub[b];
    if (in_int) begin
      e.ack = 1;
      if (!wr) e.rdata = (dw == 0) ? 32'h51C0_7A3D :
                         (dw == 6) ? {16'h0, m_sub[b], m_sec[b]} : 32'h0;
    end else if (ty0 || ty1) begin
      e.ack = 1; e.fwd = 1; e.t1 = !ty0; e.wr = wr; e.bus = bus; e.dev = dev;
      e.fn = m_addr[10:8]; e.dw = dw; e.wdata = wr ? d : 32'h0;
    end else begin
      e.rdata = wr ? 32'h0 : 32'hFFFF_FFFF;
    end
    return e;
  endfunction

  task automatic op(string tag, bit sel, bit wr, logic [31:0] d);
    for (int b = 0; b < 2; b++) begin
      item_t e = predict(b, sel, wr, d);
      if (b == 0) begin q0.push_back(e); g0.push_back(tag); end
      else        begin q1.push_back(e); g1.push_back(tag); end
    end
    for (int b = 0; b < 2; b++)
      if (sel && wr && m_addr[31] && m_addr[23:16] == 0 && m_addr[7:2] == 6 &&
          m_addr[15:11] == ((b == 1) ? 5'd26 : 5'd25)) begin
        m_sec[b] = d[7:0]; m_sub[b] = d[15:8];
      end
    if (!sel && wr) m_addr = d & 32'h80FF_FFFC;
    hreq = 1; hsel_data = sel; hwr = wr; hwdata = d;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    hreq = 0; hwr = 0; hsel_data = 0; hwdata = '0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ca(bit en, int bus, int dev, int fn, int dw);
    return {en, 7'h0, 8'(bus), 5'(dev), 3'(fn), 6'(dw), 2'b00};
  endfunction

  task automatic cmp(string who, string tag, item_t act, item_t exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", who, tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (v0) begin
      if (q0.size() == 0) begin checks++; fails++; $display("FAIL compat R11 actual=extra response expected=none"); end
      else cmp("compat", g0.pop_front(), {a0, r0, f0, t0, w0, b0, d0, fn0, dw0, wd0}, q0.pop_front());
    end else if (f0) begin checks++; fails++; $display("FAIL compat R11 actual=fwd expected=none"); end
    if (v1) begin
      if (q1.size() == 0) begin checks++; fails++; $display("FAIL aux R11 actual=extra response expected=none"); end
      else cmp("aux", g1.pop_front(), {a1, r1, f1, t1, w1, b1, d1, fn1, dw1, wd1}, q1.pop_front());
    end else if (f1) begin checks++; fails++; $display("FAIL aux R11 actual=fwd expected=none"); end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if ({v0, f0, v1, f1} !== 4'b0) begin
      fails++; $display("FAIL R1 actual=%b expected=0000", {v0, f0, v1, f1});
    end
    op("R1 R6 addr", 0, 1, ca(1, 0, 25, 0, 6));
    op("R1 R6 busreg reset", 1, 0, 0);
    op("R5 id", 0, 1, ca(1, 0, 25, 0, 0));
    op("R5 id read", 1, 0, 0);
    op("R5 zero dword", 0, 1, ca(1, 0, 25, 0, 9));
    op("R5 zero read", 1, 0, 0);
    op("R2 junk bits", 0, 1, 32'hFF12_3457);
    op("R2 readback", 0, 0, 0);
    op("R4 aux dev", 0, 1, ca(1, 0, 26, 0, 0));
    op("R4 aux id", 1, 0, 0);
    op("R4 dev20", 0, 1, ca(1, 0, 20, 0, 0));
    op("R4 dev20 read", 1, 0, 0);
    op("R7 bus0 dev3", 0, 1, ca(1, 0, 3, 2, 5));
    op("R7 R9 read", 1, 0, 0);
    op("R7 R9 write", 1, 1, 32'hCAFE_0123);
    op("R3 disabled", 0, 1, ca(0, 0, 3, 0, 0));
    op("R3 read", 1, 0, 0);
    op("R3 write", 1, 1, 32'h1234_5678);
    idle(2);
    op("R6 compat addr", 0, 1, ca(1, 0, 25, 0, 6));
    op("R6 R12 write", 1, 1, 32'hFFFF_0300);
    op("R6 R12 readback", 1, 0, 0);
    op("R8 addr bus2", 0, 1, ca(1, 2, 7, 1, 3));
    op("R8 type1", 1, 0, 0);
    op("R9 aux addr", 0, 1, ca(1, 0, 26, 0, 6));
    op("R9 R12 aux bus", 1, 1, 32'h0000_0604);
    op("R12 addr bus4", 0, 1, ca(1, 4, 20, 7, 63));
    op("R9 aux type0", 1, 1, 32'hA5A5_5A5A);
    op("R9 addr bus5", 0, 1, ca(1, 5, 1, 0, 2));
    op("R9 aux type1", 1, 0, 0);
    op("R10 addr bus7", 0, 1, ca(1, 7, 0, 0, 0));
    op("R10 read", 1, 0, 0);
    op("R10 write", 1, 1, 32'hDEAD_BEEF);
    op("R7 bus0 after", 0, 1, ca(1, 0, 15, 3, 1));
    op("R7 bus0 read", 1, 0, 0);
    idle(3);
    checks++;
    if (q0.size() != 0 || q1.size() != 0) begin
      fails++; $display("FAIL R11 actual=%0d/%0d pending expected=0/0", q0.size(), q1.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule